// File: doc/BRIEF.md
# SMBus Indexed Block Configuration Register Target

This block is a target-only serial management port for a clock fan-out device. It recovers SCL and SDA against a fast system clock with a two-flop synchroniser and edge detection, and drives SDA low through an open-drain enable. It holds a small configuration file that the output control logic reads directly: a control byte, an output-enable mask, a per-output stop mask, a spare byte and a fixed identification byte.

Every transfer names a starting register offset. A write then gives an explicit byte count before the data. A read switches direction with a repeated START. The target answers with a count byte and then streams register contents until the host declines a byte. While the power-down input is high, the block releases SDA and takes no notice of bus activity.

Top module: `smb_cfg_regs`

## Requirements
- R1: The target acknowledges only the 7-bit address 1101110 (write byte 0xDC, read byte 0xDD). Any other address is NACKed, and SDA stays released until the next START or STOP.
- R2: A write consists of address+W, an offset byte, a count N and N data bytes, and the target ACKs each of them. Data byte k is stored at register offset+k.
- R3: A count of zero is NACKed and leaves every register unchanged.
- R4: Data bytes beyond the announced count are NACKed and not stored.
- R5: A read consists of address+W, an offset, a repeated START and address+R. The target first sends a count equal to 5 minus the offset (0 when the offset is 5 or more). It then sends registers from the offset upward, one per host ACK, and stops after a host NACK.
- R6: After reset the registers are: offset 0 (control) 0x07, offset 1 (output enables, bit i = output i) 0xFF, offset 2 (stop mask) 0x00, offset 3 (spare) 0x00.
- R7: Offset 4 always reads 0x20, and writes to it are ignored.
- R8: Offsets above 4 read 0x00. Writes to them are ACKed and discarded. The running index saturates at 0xFF instead of wrapping.
- R9: A STOP or a START at any point abandons the current transfer. Bytes already ACKed stay stored.
- R10: While power-down is high, SDA is released, no transfer is acknowledged and no register changes.
- R11: The target only begins pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn | input | 1 | Power-down; the bus is ignored while high |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_ctrl | output | 8 | Control byte (offset 0) |
| cfg_oe | output | 8 | Output enable mask (offset 1) |
| cfg_stop | output | 8 | Stop-control mask (offset 2) |
| cfg_spare | output | 8 | Spare read/write byte (offset 3) |

## Verification
The bench sends a zero count and expects a NACK. A design that took it as a huge count would go on to store the following bytes. It sends more bytes than announced, and a design with a count that wraps would overwrite the next register. It reads from offsets near the top of the index range, where an index that wraps returns live registers instead of zeros. It also cuts a write with a START in the middle of a byte and then reads the data back; a design that fails to abandon the transfer would store garbage or lose the repeated START. Finally it repeats a full write while power-down is high, and a design that still listens would ACK the write and change the outputs.

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs #(
  parameter logic [6:0] DEV_ADDR = 7'h6E,
  parameter logic [7:0] ID_VAL   = 8'h20,
  parameter logic [7:0] CTRL_RST = 8'h07,
  parameter int         NREG     = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrdn,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  output logic [7:0] cfg_ctrl,
  output logic [7:0] cfg_oe,
  output logic [7:0] cfg_stop,
  output logic [7:0] cfg_spare
);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_OFFS, S_CNT, S_WDAT, S_RACK, S_RCNT, S_RDAT, S_IGN
  } st_t;

  st_t        st;
  logic [2:0] scl_p, sda_p;
  logic [3:0] bitcnt;
  logic [7:0] shreg, tx, idx, wcnt;
  logic       mack;

  wire scl_rise  = scl_p[1] & ~scl_p[2];
  wire scl_fall  = ~scl_p[1] & scl_p[2];
  wire bus_start = scl_p[1] & scl_p[2] & ~sda_p[1] & sda_p[2];
  wire bus_stop  = scl_p[1] & scl_p[2] & sda_p[1] & ~sda_p[2];

  wire [7:0] idx_nx = (idx == 8'hFF) ? idx : idx + 8'd1;
  wire [7:0] remain = (idx < 8'(NREG)) ? (8'(NREG) - idx) : 8'h00;

  function automatic logic [7:0] rd_byte(input logic [7:0] i);
    case (i)
      8'd0:    rd_byte = cfg_ctrl;
      8'd1:    rd_byte = cfg_oe;
      8'd2:    rd_byte = cfg_stop;
      8'd3:    rd_byte = cfg_spare;
      8'd4:    rd_byte = ID_VAL;
      default: rd_byte = 8'h00;
    endcase
  endfunction

  wire [7:0] rd_cur = rd_byte(idx);
  wire [7:0] rd_nx  = rd_byte(idx_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      tx        <= '0;
      idx       <= '0;
      wcnt      <= '0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      cfg_ctrl  <= CTRL_RST;
      cfg_oe    <= 8'hFF;
      cfg_stop  <= 8'h00;
      cfg_spare <= 8'h00;
    end else if (pwrdn) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (bus_start) begin
      st     <= S_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (bus_stop) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_p[1]};
        if (bitcnt == 4'd8) mack <= ~sda_p[1];
        bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          case (st)
            S_ADDR:
              if (shreg[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                st     <= shreg[0] ? S_RACK : S_OFFS;
              end else st <= S_IGN;
            S_OFFS: begin
              sda_oe <= 1'b1;
              idx    <= shreg;
              st     <= S_CNT;
            end
            S_CNT:
              if (shreg != 8'h00) begin
                sda_oe <= 1'b1;
                wcnt   <= shreg;
                st     <= S_WDAT;
              end else st <= S_IGN;
            S_WDAT:
              if (wcnt != 8'h00) begin
                sda_oe <= 1'b1;
                wcnt   <= wcnt - 8'd1;
                idx    <= idx_nx;
                case (idx)
                  8'd0:    cfg_ctrl  <= shreg;
                  8'd1:    cfg_oe    <= shreg;
                  8'd2:    cfg_stop  <= shreg;
                  8'd3:    cfg_spare <= shreg;
                  default: ;
                endcase
              end else st <= S_IGN;
            default: sda_oe <= 1'b0;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          case (st)
            S_RACK: begin
              st     <= S_RCNT;
              tx     <= remain;
              sda_oe <= ~remain[7];
            end
            S_RCNT:
              if (mack) begin
                st     <= S_RDAT;
                tx     <= rd_cur;
                sda_oe <= ~rd_cur[7];
              end else begin
                st     <= S_IGN;
                sda_oe <= 1'b0;
              end
            S_RDAT:
              if (mack) begin
                idx    <= idx_nx;
                tx     <= rd_nx;
                sda_oe <= ~rd_nx[7];
              end else begin
                st     <= S_IGN;
                sda_oe <= 1'b0;
              end
            default: sda_oe <= 1'b0;
          endcase
        end else if (bitcnt != 4'd0 && (st == S_RCNT || st == S_RDAT)) begin
          sda_oe <= ~tx[3'd7 - bitcnt[2:0]];
        end
      end
    end
  end

  p_pd_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn |=> !sda_oe);

  p_pd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn |=> $stable({cfg_ctrl, cfg_oe, cfg_stop, cfg_spare}));

  p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_p[2]);

  p_ign_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN && $past(st) == S_IGN) |-> !sda_oe);

  p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDAT && wcnt == 8'h00) |=> $stable({cfg_ctrl, cfg_oe, cfg_stop, cfg_spare}));

  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !sda_oe);

endmodule

// File: tb/smb_cfg_regs_tb_top.sv
`timescale 1ns/1ps
module smb_cfg_regs_tb_top;
  localparam int Q = 100;

  logic clk = 1'b0, rst_n = 1'b0, pwrdn = 1'b0, m_scl = 1'b1, m_low = 1'b0;
  wire        sda_oe;
  wire [7:0]  c_ctrl, c_oe, c_stop, c_spare;
  wire        sda_line = ~(m_low | sda_oe);

  always #5 clk = ~clk;

  smb_cfg_regs dut_i (
    .clk(clk), .rst_n(rst_n), .pwrdn(pwrdn), .scl_in(m_scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .cfg_ctrl(c_ctrl), .cfg_oe(c_oe), .cfg_stop(c_stop), .cfg_spare(c_spare)
  );

  int checks = 0, fails = 0, viol = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       prev_oe = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic monitor_cmp(input logic [7:0] got);
    logic [7:0] e;
    string t;
    if (exp_q.size() == 0) begin
      check(1'b0, "R5 unexpected byte", got, 0);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(got == e, t, got, e);
    end
  endtask

  always @(negedge clk) begin
    if (sda_oe && !prev_oe && m_scl) viol++;
    prev_oe <= sda_oe;
  end

  task automatic wbit(input bit b);
    m_low = ~b; #Q m_scl = 1'b1; #(2*Q) m_scl = 1'b0; #Q;
  endtask

  task automatic rbit(output bit b);
    m_low = 1'b0; #Q m_scl = 1'b1; #Q b = sda_line; #Q m_scl = 1'b0; #Q;
  endtask

  task automatic bstart();
    m_low = 1'b0; #Q m_scl = 1'b1; #Q m_low = 1'b1; #Q m_scl = 1'b0; #Q;
  endtask

  task automatic bstop();
    m_low = 1'b1; #Q m_scl = 1'b1; #Q m_low = 1'b0; #(2*Q);
  endtask

  task automatic send(input logic [7:0] b, input bit exp_ack, input string tag);
    bit a;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(a);
    check((a == 1'b0) == exp_ack, tag, a, !exp_ack);
  endtask

  task automatic recv(input bit ack);
    bit x;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      rbit(x);
      got[i] = x;
    end
    wbit(!ack);
    monitor_cmp(got);
  endtask

  task automatic rd_txn(input logic [7:0] off, input int n);
    bstart();
    send(8'hDC, 1'b1, "R1 addr ack");
    send(off, 1'b1, "R5 offset ack");
    bstart();
    send(8'hDD, 1'b1, "R5 read addr ack");
    recv(1'b1);
    for (int i = 0; i < n; i++) recv(i != n - 1);
    bstop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1'b1, "watchdog", 0, 0);
    checks--;
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #50 rst_n = 1'b1;
    @(negedge clk);
    #(2*Q);
    // R6 reset values
    check(c_ctrl == 8'h07, "R6 ctrl", c_ctrl, 8'h07);
    check(c_oe == 8'hFF, "R6 oe", c_oe, 8'hFF);
    check(c_stop == 8'h00, "R6 stop", c_stop, 8'h00);
    check(c_spare == 8'h00, "R6 spare", c_spare, 8'h00);
    check(sda_oe == 1'b0, "R6 sda released", sda_oe, 0);

    // R2 block write of four bytes from offset 0
    bstart();
    send(8'hDC, 1'b1, "R1 addr ack");
    send(8'h00, 1'b1, "R2 offset ack");
    send(8'h04, 1'b1, "R2 count ack");
    send(8'hA5, 1'b1, "R2 data0 ack");
    send(8'h3C, 1'b1, "R2 data1 ack");
    send(8'hC3, 1'b1, "R2 data2 ack");
    send(8'h5A, 1'b1, "R2 data3 ack");
    bstop();
    check(c_ctrl == 8'hA5, "R2 ctrl", c_ctrl, 8'hA5);
    check(c_oe == 8'h3C, "R2 oe", c_oe, 8'h3C);
    check(c_stop == 8'hC3, "R2 stop", c_stop, 8'hC3);
    check(c_spare == 8'h5A, "R2 spare", c_spare, 8'h5A);

    // R5 / R7 full read from offset 0
    push(8'h05, "R5 count off0");
    push(8'hA5, "R5 byte0"); push(8'h3C, "R5 byte1"); push(8'hC3, "R5 byte2");
    push(8'h5A, "R5 byte3"); push(8'h20, "R7 id");
    rd_txn(8'h00, 5);

    // R5 read from offset 2
    push(8'h03, "R5 count off2");
    push(8'hC3, "R5 off2 byte0"); push(8'h5A, "R5 off2 byte1"); push(8'h20, "R7 id off2");
    rd_txn(8'h02, 3);

    // R7 / R8 write into the id and beyond
    bstart();
    send(8'hDC, 1'b1, "R1 addr ack");
    send(8'h04, 1'b1, "R7 offset ack");
    send(8'h03, 1'b1, "R7 count ack");
    send(8'hFF, 1'b1, "R7 id write ack");
    send(8'hEE, 1'b1, "R8 beyond ack");
    send(8'hDD, 1'b1, "R8 beyond ack");
    bstop();
    push(8'h02, "R5 count off3");
    push(8'h5A, "R8 spare kept"); push(8'h20, "R7 id unchanged");
    push(8'h00, "R8 off5 zero"); push(8'h00, "R8 off6 zero");
    rd_txn(8'h03, 4);

    // R8 saturating index near the top
    push(8'h00, "R8 count high off");
    push(8'h00, "R8 FE"); push(8'h00, "R8 FF"); push(8'h00, "R8 saturated");
    rd_txn(8'hFE, 3);

    // R3 zero count
    bstart();
    send(8'hDC, 1'b1, "R1 addr ack");
    send(8'h01, 1'b1, "R3 offset ack");
    send(8'h00, 1'b0, "R3 zero count nack");
    send(8'h99, 1'b0, "R3 data after zero count nack");
    bstop();
    check(c_oe == 8'h3C, "R3 oe unchanged", c_oe, 8'h3C);

    // R4 bytes beyond the count
    bstart();
    send(8'hDC, 1'b1, "R1 addr ack");
    send(8'h02, 1'b1, "R4 offset ack");
    send(8'h01, 1'b1, "R4 count ack");
    send(8'h11, 1'b1, "R4 data ack");
    send(8'h22, 1'b0, "R4 extra nack");
    bstop();
    check(c_stop == 8'h11, "R4 stop", c_stop, 8'h11);
    check(c_spare == 8'h5A, "R4 spare untouched", c_spare, 8'h5A);

    // R1 foreign address
    bstart();
    send(8'hDE, 1'b0, "R1 wrong addr nack");
    send(8'h00, 1'b0, "R1 ignored offset");
    send(8'h01, 1'b0, "R1 ignored count");
    send(8'h00, 1'b0, "R1 ignored data");
    bstop();
    check(c_ctrl == 8'hA5, "R1 ctrl unchanged", c_ctrl, 8'hA5);

    // R9 STOP abort keeps committed bytes
    bstart();
    send(8'hDC, 1'b1, "R1 addr ack");
    send(8'h00, 1'b1, "R9 offset ack");
    send(8'h03, 1'b1, "R9 count ack");
    send(8'h01, 1'b1, "R9 data ack");
    bstop();
    check(c_ctrl == 8'h01, "R9 ctrl committed", c_ctrl, 8'h01);
    check(c_oe == 8'h3C, "R9 oe untouched", c_oe, 8'h3C);

    // R9 START in the middle of a byte, then read back
    bstart();
    send(8'hDC, 1'b1, "R1 addr ack");
    send(8'h01, 1'b1, "R9 offset ack");
    send(8'h02, 1'b1, "R9 count ack");
    send(8'h0F, 1'b1, "R9 data ack");
    wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b0);
    push(8'h04, "R9 count after restart");
    push(8'h0F, "R9 oe committed"); push(8'h11, "R9 stop untouched");
    rd_txn(8'h01, 2);
    check(c_oe == 8'h0F, "R9 oe port", c_oe, 8'h0F);

    // R10 power-down ignores the bus
    pwrdn = 1'b1;
    #(2*Q);
    bstart();
    send(8'hDC, 1'b0, "R10 addr nack");
    send(8'h01, 1'b0, "R10 offset nack");
    send(8'h01, 1'b0, "R10 count nack");
    send(8'h77, 1'b0, "R10 data nack");
    bstop();
    check(c_oe == 8'h0F, "R10 oe unchanged", c_oe, 8'h0F);
    check(sda_oe == 1'b0, "R10 sda released", sda_oe, 0);
    pwrdn = 1'b0;
    #(2*Q);
    push(8'h05, "R10 count after wake");
    push(8'h01, "R10 ctrl after wake");
    rd_txn(8'h00, 1);

    // R11 SDA drive only begins with SCL low
    check(viol == 0, "R11 drive while scl high", viol, 0);
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule